// File: doc/BRIEF.md
# Dual-Tone Digit Frequency Classifier

This block takes the two limited square waves that an analog front end produces from a dual-tone keypad signal. One wave comes from the low-frequency band and the other from the high-frequency band. The block tells which of the sixteen keypad digits is present. For each wave it counts system-clock cycles from one rising edge to the next. It then compares that period with a window around each of the four nominal tones of the band. A group counts as holding a tone only after several consecutive periods have all fallen into the same window.

The block reports a 2-bit row index for the low band and a 2-bit column index for the high band. An early-steer flag is high while both bands hold a valid tone at the same time. The flag drops as soon as either band loses its tone, through an out-of-window period or a missing edge. Guard timing, latching of the digit code and all analog processing stay with the surrounding logic.

With the default 3.579545 MHz clock and eight averaged periods, early-steer asserts about 9.6 to 12.9 ms after tone onset. It drops within about 1.5 ms after the tone stops.

Top module: `dtmf_pair_classifier`

## Requirements
- R1: After reset `early_steer_o` is 0 and `row_o` and `col_o` are both 0.
- R2: A measured period P, in clock cycles, matches tone k of a band when P*f*(1000+TOL_PM) >= CLK_HZ*1000 and P*f*(1000-TOL_PM) <= CLK_HZ*1000, where f is the tone frequency. The low band tones 697, 770, 852 and 941 Hz are row indices 0 to 3. The high band tones 1209, 1336, 1477 and 1633 Hz are column indices 0 to 3. With the default TOL_PM of 25, every tone within 1.5% plus 2 Hz of nominal is accepted, and every tone 3.5% or more away from all nominals is rejected.
- R3: A band is valid only after AVG_LEN (default 8) consecutive measured periods all match the same tone. The first rising edge after idle, reset, power-down or a timeout only starts the measurement and yields no period.
- R4: `early_steer_o` is high exactly when both bands are valid. A measured period that matches no tone makes its band invalid.
- R5: A matching period for a tone different from the band's current tone restarts the count of consecutive periods at one for the new tone.
- R6: If no rising edge arrives within the longest accepted period of the band's lowest tone plus one cycle, that band becomes invalid and its measurement restarts at the next edge.
- R7: While `pd_i` is high at a clock edge, all counters and both indices are cleared, and `early_steer_o` is 0 from that edge on.
- R8: A rising input edge seen before clock edge n is counted as a period end at edge n+2. Band validity, and with it `early_steer_o`, changes at edge n+3.
- R9: `row_o` and `col_o` show the tone of the most recent matching period of their band. Non-matching periods and timeouts leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Synchronous power-down, active high |
| low_tone_i | input | 1 | Limited low-band square wave, asynchronous |
| high_tone_i | input | 1 | Limited high-band square wave, asynchronous |
| row_o | output | 2 | Low-band tone index |
| col_o | output | 2 | High-band tone index |
| early_steer_o | output | 1 | Both bands hold a valid tone |

## Verification
An input edge reaches the period register two clock edges after it is sampled, and the band state one edge later. The bench reference model therefore uses a three-deep history of input samples and updates the band state from the previous cycle's period sample. The outputs are compared on every falling edge, after all three register stages have settled. At the end of each stimulus phase, directed checks also assert the expected index and early-steer value. Each phase waits long enough for eight full periods of its slowest tone, a timeout window or a tone change to pass through these stages.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  typedef logic [1:0] tone_idx_t;

  localparam int unsigned NUM_TONES = 4;

  // grp 0: low band, grp 1: high band
  function automatic int unsigned tone_hz(input int unsigned grp, input int unsigned k);
    case (grp * 4 + k)
      0: return 697;
      1: return 770;
      2: return 852;
      3: return 941;
      4: return 1209;
      5: return 1336;
      6: return 1477;
      7: return 1633;
      default: return 1000;
    endcase
  endfunction

  // shortest accepted period (ceil)
  function automatic int unsigned band_lo(input int unsigned clk_hz, input int unsigned f,
                                          input int unsigned tol_pm);
    longint num, den;
    num = longint'(clk_hz) * 1000;
    den = longint'(f) * (1000 + tol_pm);
    return int'((num + den - 1) / den);
  endfunction

  // longest accepted period (floor)
  function automatic int unsigned band_hi(input int unsigned clk_hz, input int unsigned f,
                                          input int unsigned tol_pm);
    longint num, den;
    num = longint'(clk_hz) * 1000;
    den = longint'(f) * (1000 - tol_pm);
    return int'(num / den);
  endfunction

endpackage

// File: rtl/dtmf_period_meter.sv
module dtmf_period_meter #(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned TOUT  = 5268
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             tone_i,
  output logic             per_vld_o,
  output logic [CNT_W-1:0] per_o,
  output logic             tout_o
);

  logic [2:0]       sync_q;
  logic             rise;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tone_i};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      per_vld_o <= 1'b0;
      per_o     <= '0;
      tout_o    <= 1'b0;
    end else if (pd_i) begin
      cnt_q     <= '0;
      armed_q   <= 1'b0;
      per_vld_o <= 1'b0;
      tout_o    <= 1'b0;
    end else begin
      per_vld_o <= 1'b0;
      tout_o    <= 1'b0;
      if (rise) begin
        // first edge after idle only arms
        per_vld_o <= armed_q;
        per_o     <= cnt_q;
        cnt_q     <= CNT_W'(1);
        armed_q   <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q == CNT_W'(TOUT)) begin
          tout_o  <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  p_period_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_vld_o |-> (per_o != '0 && per_o <= CNT_W'(TOUT)));

  p_disarm_after_tout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_o |=> !per_vld_o);

endmodule

// File: rtl/dtmf_band_match.sv
module dtmf_band_match
  import dtmf_pkg::*;
#(
  parameter int unsigned GRP    = 0,
  parameter int unsigned CLK_HZ = 3579545,
  parameter int unsigned TOL_PM = 25,
  parameter int unsigned CNT_W  = 13
) (
  input  logic [CNT_W-1:0] per_i,
  output logic             hit_o,
  output tone_idx_t        idx_o
);

  logic [NUM_TONES-1:0] in_band;

  for (genvar k = 0; k < NUM_TONES; k++) begin : g_band
    localparam int unsigned LO = band_lo(CLK_HZ, tone_hz(GRP, k), TOL_PM);
    localparam int unsigned HI = band_hi(CLK_HZ, tone_hz(GRP, k), TOL_PM);
    assign in_band[k] = (per_i >= CNT_W'(LO)) && (per_i <= CNT_W'(HI));
  end

  // windows are disjoint, so the encoder order is irrelevant
  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NUM_TONES; k++) begin
      if (in_band[k]) idx_o = tone_idx_t'(k);
    end
  end

  assign hit_o = |in_band;

endmodule

// File: rtl/dtmf_group_track.sv
module dtmf_group_track
  import dtmf_pkg::*;
#(
  parameter int unsigned AVG_LEN = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_i,
  input  logic      per_vld_i,
  input  logic      hit_i,
  input  tone_idx_t idx_i,
  input  logic      tout_i,
  output logic      valid_o,
  output tone_idx_t idx_o
);

  localparam int unsigned RUN_W = $clog2(AVG_LEN + 1);

  logic [RUN_W-1:0] run_q;
  tone_idx_t        band_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      band_q <= '0;
    end else if (pd_i) begin
      run_q  <= '0;
      band_q <= '0;
    end else if (tout_i) begin
      run_q <= '0;
    end else if (per_vld_i) begin
      if (!hit_i) begin
        run_q <= '0;
      end else if (idx_i == band_q) begin
        if (run_q != RUN_W'(AVG_LEN)) run_q <= run_q + RUN_W'(1);
      end else begin
        band_q <= idx_i;
        run_q  <= RUN_W'(1);
      end
    end
  end

  assign valid_o = (run_q == RUN_W'(AVG_LEN));
  assign idx_o   = band_q;

  p_run_bounded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(AVG_LEN));

  p_miss_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_vld_i && !hit_i) |=> (run_q == '0));

  p_band_switch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && !tout_i && per_vld_i && hit_i && idx_i != band_q)
      |=> (run_q == RUN_W'(1) && band_q == $past(idx_i)));

  p_tout_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_i |=> !valid_o);

  p_miss_keeps_idx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && (tout_i || (per_vld_i && !hit_i))) |=> $stable(band_q));

endmodule

// File: rtl/dtmf_pair_classifier.sv
module dtmf_pair_classifier
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 3579545,
  parameter int unsigned TOL_PM  = 25,
  parameter int unsigned AVG_LEN = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_i,
  input  logic       low_tone_i,
  input  logic       high_tone_i,
  output logic [1:0] row_o,
  output logic [1:0] col_o,
  output logic       early_steer_o
);

  // low band has the longest periods; it sizes the shared counter width
  localparam int unsigned TOUT_MAX = band_hi(CLK_HZ, tone_hz(0, 0), TOL_PM) + 1;
  localparam int unsigned CNT_W    = $clog2(TOUT_MAX + 1);

  logic [1:0]       tone_in;
  logic [1:0]       per_vld;
  logic [1:0]       hit;
  logic [1:0]       tout;
  logic [1:0]       grp_valid;
  logic [CNT_W-1:0] per       [2];
  tone_idx_t        match_idx [2];
  tone_idx_t        grp_idx   [2];

  assign tone_in = {high_tone_i, low_tone_i};

  for (genvar g = 0; g < 2; g++) begin : g_grp
    localparam int unsigned TOUT_G = band_hi(CLK_HZ, tone_hz(g, 0), TOL_PM) + 1;

    dtmf_period_meter #(
      .CNT_W (CNT_W),
      .TOUT  (TOUT_G)
    ) u_meter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pd_i      (pd_i),
      .tone_i    (tone_in[g]),
      .per_vld_o (per_vld[g]),
      .per_o     (per[g]),
      .tout_o    (tout[g])
    );

    dtmf_band_match #(
      .GRP    (g),
      .CLK_HZ (CLK_HZ),
      .TOL_PM (TOL_PM),
      .CNT_W  (CNT_W)
    ) u_match (
      .per_i (per[g]),
      .hit_o (hit[g]),
      .idx_o (match_idx[g])
    );

    dtmf_group_track #(
      .AVG_LEN (AVG_LEN)
    ) u_track (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pd_i      (pd_i),
      .per_vld_i (per_vld[g]),
      .hit_i     (hit[g]),
      .idx_i     (match_idx[g]),
      .tout_i    (tout[g]),
      .valid_o   (grp_valid[g]),
      .idx_o     (grp_idx[g])
    );
  end

  assign row_o         = grp_idx[0];
  assign col_o         = grp_idx[1];
  assign early_steer_o = &grp_valid;

  p_pd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !early_steer_o);

  p_est_after_sample_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(early_steer_o) |-> $past(|per_vld));

endmodule

// File: tb/dtmf_pair_classifier_tb_top.sv
module dtmf_pair_classifier_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 400000;
  localparam int TOL_PM     = 25;
  localparam int AVG_LEN    = 8;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pd = 1'b0;
  logic       lo_sig = 1'b0;
  logic       hi_sig = 1'b0;
  logic [1:0] row, col;
  logic       est;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dtmf_pair_classifier #(
    .CLK_HZ  (CLK_HZ),
    .TOL_PM  (TOL_PM),
    .AVG_LEN (AVG_LEN)
  ) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .pd_i          (pd),
    .low_tone_i    (lo_sig),
    .high_tone_i   (hi_sig),
    .row_o         (row),
    .col_o         (col),
    .early_steer_o (est)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  int    cycles   = 0;
  bit    done     = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  function automatic int hz(input int g, input int k);
    int lo_t[4] = '{697, 770, 852, 941};
    int hi_t[4] = '{1209, 1336, 1477, 1633};
    return (g == 0) ? lo_t[k] : hi_t[k];
  endfunction

  // R2 window test written as products, no division
  function automatic int classify(input int g, input int p);
    longint ref_n = longint'(CLK_HZ) * 1000;
    for (int k = 0; k < 4; k++) begin
      longint pf = longint'(p) * hz(g, k);
      if (pf * (1000 + TOL_PM) >= ref_n && pf * (1000 - TOL_PM) <= ref_n) return k;
    end
    return -1;
  endfunction

  function automatic int longest(input int g, input int k);
    return int'((longint'(CLK_HZ) * 1000) / (longint'(hz(g, k)) * (1000 - TOL_PM)));
  endfunction

  function automatic int nominal(input int g, input int k);
    return (CLK_HZ + hz(g, k) / 2) / hz(g, k);
  endfunction

  // tone generators: period in cycles, 0 = silent
  int per_set[2] = '{0, 0};
  int phase[2]   = '{0, 0};

  always @(negedge clk) begin
    for (int g = 0; g < 2; g++) begin
      logic s;
      if (per_set[g] == 0) begin
        phase[g] = 0;
        s = 1'b0;
      end else begin
        phase[g] = (phase[g] + 1) % per_set[g];
        s = (phase[g] < per_set[g] / 2);
      end
      if (g == 0) lo_sig = s;
      else        hi_sig = s;
    end
  end

  // behavioural reference model
  int  m_hist[2][$];
  int  m_cnt[2], m_arm[2], m_pv[2], m_pval[2], m_tout[2], m_run[2], m_band[2];
  int  m_est, m_row, m_col;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin
        m_hist[g] = {0, 0, 0};
        m_cnt[g] = 0; m_arm[g] = 0; m_pv[g] = 0; m_pval[g] = 0;
        m_tout[g] = 0; m_run[g] = 0; m_band[g] = 0;
      end
    end else begin
      for (int g = 0; g < 2; g++) begin
        int b, rise, limit;
        limit = longest(g, 0) + 1;
        if (pd) begin
          m_run[g] = 0; m_band[g] = 0;
        end else if (m_tout[g] != 0) begin
          m_run[g] = 0;
        end else if (m_pv[g] != 0) begin
          b = classify(g, m_pval[g]);
          if (b < 0)              m_run[g] = 0;
          else if (b == m_band[g]) m_run[g] = (m_run[g] < AVG_LEN) ? m_run[g] + 1 : AVG_LEN;
          else begin
            m_band[g] = b; m_run[g] = 1;
          end
        end
        rise = (m_hist[g][1] == 1 && m_hist[g][2] == 0) ? 1 : 0;
        if (pd) begin
          m_cnt[g] = 0; m_arm[g] = 0; m_pv[g] = 0; m_tout[g] = 0;
        end else begin
          m_pv[g] = 0; m_tout[g] = 0;
          if (rise != 0) begin
            m_pv[g] = m_arm[g]; m_pval[g] = m_cnt[g]; m_cnt[g] = 1; m_arm[g] = 1;
          end else if (m_arm[g] != 0) begin
            if (m_cnt[g] == limit) begin
              m_tout[g] = 1; m_arm[g] = 0; m_cnt[g] = 0;
            end else m_cnt[g]++;
          end
        end
        m_hist[g].push_front((g == 0) ? int'(lo_sig) : int'(hi_sig));
        void'(m_hist[g].pop_back());
      end
    end
    m_est = (m_run[0] == AVG_LEN && m_run[1] == AVG_LEN) ? 1 : 0;
    m_row = m_band[0];
    m_col = m_band[1];
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      check({"R8/", cur_req}, "early_steer", int'(est), m_est);
      check({"R8/", cur_req}, "row", int'(row), m_row);
      check({"R8/", cur_req}, "col", int'(col), m_col);
    end
    if (cycles > WD_LIMIT && !done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WD_LIMIT);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    check("R1", "early_steer in reset", int'(est), 0);
    check("R1", "row in reset", int'(row), 0);
    check("R1", "col in reset", int'(col), 0);
    rst_n = 1'b1;
    wait_cyc(3);
    check("R1", "early_steer after reset", int'(est), 0);

    // pair row 1, col 2
    cur_req = "R3";
    per_set[0] = nominal(0, 1);
    per_set[1] = nominal(1, 2);
    wait_cyc(AVG_LEN * nominal(0, 1) / 2);
    check("R3", "early_steer before window full", int'(est), 0);
    wait_cyc(AVG_LEN * nominal(0, 1));
    check("R4", "early_steer with pair", int'(est), 1);
    check("R2", "row 770 Hz", int'(row), 1);
    check("R2", "col 1477 Hz", int'(col), 2);

    // low band between windows
    cur_req = "R9";
    per_set[0] = (nominal(0, 0) + nominal(0, 1)) / 2;
    wait_cyc(3 * nominal(0, 0));
    check("R4", "early_steer with rejected low tone", int'(est), 0);
    check("R9", "row kept after rejected periods", int'(row), 1);

    // new pair row 3, col 0
    cur_req = "R2";
    per_set[0] = nominal(0, 3);
    per_set[1] = nominal(1, 0);
    wait_cyc((AVG_LEN + 4) * nominal(0, 3));
    check("R4", "early_steer pair 941/1209", int'(est), 1);
    check("R2", "row 941 Hz", int'(row), 3);
    check("R2", "col 1209 Hz", int'(col), 0);

    // high band jumps to col 3
    cur_req = "R5";
    per_set[1] = nominal(1, 3);
    wait_cyc(900);
    check("R5", "early_steer restarts on tone change", int'(est), 0);
    check("R5", "col follows new tone", int'(col), 3);
    wait_cyc(2500);
    check("R5", "early_steer after new window", int'(est), 1);

    // low band goes silent
    cur_req = "R6";
    per_set[0] = 0;
    wait_cyc(longest(0, 0) + nominal(0, 3) + 40);
    check("R6", "early_steer after missing edges", int'(est), 0);
    check("R9", "row kept after timeout", int'(row), 3);

    // power-down
    cur_req = "R7";
    per_set[0] = nominal(0, 0);
    wait_cyc((AVG_LEN + 3) * nominal(0, 0));
    check("R4", "early_steer pair 697/1633", int'(est), 1);
    pd = 1'b1;
    wait_cyc(2);
    check("R7", "early_steer in power-down", int'(est), 0);
    check("R7", "row cleared", int'(row), 0);
    check("R7", "col cleared", int'(col), 0);
    wait_cyc(300);
    check("R7", "early_steer held low", int'(est), 0);
    pd = 1'b0;
    wait_cyc((AVG_LEN + 3) * nominal(0, 0));
    check("R7", "early_steer after power-up", int'(est), 1);

    // window edges of the 697 Hz tone
    cur_req = "R2";
    per_set[0] = longest(0, 0);
    wait_cyc((AVG_LEN + 3) * longest(0, 0));
    check("R2", "longest accepted low period", int'(est), 1);
    check("R2", "row at window edge", int'(row), 0);
    per_set[0] = longest(0, 0) + 1;
    wait_cyc(3 * longest(0, 0));
    check("R6", "one cycle past window", int'(est), 0);

    per_set[0] = 0;
    per_set[1] = 0;
    wait_cyc(20);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule